// File: doc/BRIEF.md
# Calorimeter Pulse Energy Peak Finder

The block receives one digitized calorimeter sample per bunch crossing. A shaped pulse spreads its charge over several crossings, so the block adds up the most recent six samples and keeps a running window sum for each crossing. It then compares each sum with the sums on either side of it. The crossing whose window sum is the local maximum receives the whole pulse energy, and neighbouring crossings receive none.

Only crossings that win this comparison produce an output word. Every other crossing, including all crossings that carry no energy, is dropped from the stream. Each emitted word holds a compressed 8-bit energy code, a crossing number that keeps the sparse stream aligned in time, and a flag that shows whether the raw window sum reached a programmable threshold. The compression is piecewise linear. Small energies keep full resolution, and larger energies are coarsened in two steps.

The block can sit directly behind an ADC sample stream, with one instance per channel. A sample strobe marks the crossings that carry data. Clock cycles without the strobe leave all state unchanged.

Top module: `calo_peak_finder`

## Requirements
- R1: While `rst` is high at a clock edge, every output is cleared to zero. The sample history, the window fill count and the crossing counter restart from zero.
- R2: The window sum for accepted sample k (zero-based since reset, k >= 5) is the sum of samples k-5 through k. It saturates at 8191.
- R3: No word is emitted for a window that holds fewer than six samples. The earliest possible word describes sample 5 and appears when sample 6 is accepted.
- R4: The window sum of sample k is a peak when it is strictly greater than the sum of sample k-1 and greater than or equal to the sum of sample k+1. For k = 5, the sum of sample k-1 counts as 0.
- R5: `out_valid` is high for exactly one cycle, in the cycle after the edge that accepts sample k+1, and only when sample k is a peak. In all other cycles it is low, so zero-energy crossings are never emitted.
- R6: For a window sum S, `out_energy` is S when S < 64, 64 + (S-64)/4 when 64 <= S < 320, and 128 + (S-320)/16 otherwise, clamped to 255. Both divisions round down.
- R7: `out_over_thr` is 1 when the emitted window sum is greater than or equal to `thresh`, using the `thresh` value present at the edge that emits the word. It is 0 whenever `out_valid` is 0.
- R8: `out_bx` carries the zero-based index since reset of the newest sample in the peak window, modulo 4096.
- R9: A cycle with `smp_valid` low accepts no sample, leaves the window and the peak state unchanged, and leaves `out_valid` low in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| smp_valid | input | 1 | Sample strobe, one per crossing |
| smp_data | input | 10 | Unsigned ADC sample |
| thresh | input | 13 | Threshold for the window sum |
| out_valid | output | 1 | Peak word present |
| out_energy | output | 8 | Range-compressed window energy |
| out_bx | output | 12 | Crossing index of the peak window |
| out_over_thr | output | 1 | Window sum is at or above the threshold |

## Verification
Two behaviours can meet in the same acceptance edge. The peak decision for one crossing is made in the same edge that accepts the next sample and starts the window that may follow it. When the window first fills, the first complete window can also be a peak. The bench provokes both situations with flat plateaus of equal sums, single-sample spikes, a block of full-scale samples at the start of the stream, and a reset in the middle of the stream. For every accepted sample it compares the presence of a word, the energy code, the crossing index and the threshold flag with a model of six-sample sums that it computes arithmetically. It also sweeps every spike amplitude from 1 to 1023 across all three compression segments and puts the threshold exactly at the sum.

// File: rtl/cpf_pkg.sv
`timescale 1ns/1ps
package cpf_pkg;
    localparam int unsigned DEF_SAMPLE_W = 10;
    localparam int unsigned DEF_WIN      = 6;
    localparam int unsigned DEF_SUM_W    = 13;
    localparam int unsigned DEF_CODE_W   = 8;
    localparam int unsigned DEF_CNT_W    = 12;
    localparam int unsigned DEF_LO_END   = 64;
    localparam int unsigned DEF_MID_END  = 320;
    localparam int unsigned DEF_MID_SH   = 2;
    localparam int unsigned DEF_HI_SH    = 4;

    typedef enum logic [1:0] {
        SEG_FINE   = 2'd0,
        SEG_MEDIUM = 2'd1,
        SEG_COARSE = 2'd2
    } seg_e;
endpackage

// File: rtl/cpf_window_sum.sv
`timescale 1ns/1ps
module cpf_window_sum
    import cpf_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned WIN      = DEF_WIN,
    parameter int unsigned SUM_W    = DEF_SUM_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                accept,
    input  logic [SAMPLE_W-1:0] sample,
    output logic [SUM_W-1:0]    win_sum,
    output logic                win_full
);
    localparam int unsigned HIST_N = WIN - 1;
    localparam int unsigned FILL_W = $clog2(WIN) + 1;
    localparam int unsigned RAW_W  = SAMPLE_W + $clog2(WIN) + 1;
    localparam int unsigned ACC_W  = (RAW_W > SUM_W) ? RAW_W : SUM_W + 1;
    localparam logic [ACC_W-1:0] SUM_MAX = ACC_W'({SUM_W{1'b1}});

    typedef struct packed {
        logic [HIST_N-1:0][SAMPLE_W-1:0] hist;
        logic [FILL_W-1:0]               fill;
    } win_state_t;

    win_state_t st_d, st_q;
    logic [ACC_W-1:0] acc;

    always_comb begin
        acc = ACC_W'(sample);
        for (int i = 0; i < int'(HIST_N); i++) begin
            acc = acc + ACC_W'(st_q.hist[i]);
        end
        win_sum  = (acc > SUM_MAX) ? {SUM_W{1'b1}} : acc[SUM_W-1:0];
        win_full = (st_q.fill == FILL_W'(HIST_N));

        st_d = st_q;
        if (accept) begin
            st_d.hist[0] = sample;
            for (int i = 1; i < int'(HIST_N); i++) begin
                st_d.hist[i] = st_q.hist[i-1];
            end
            if (st_q.fill != FILL_W'(HIST_N)) begin
                st_d.fill = st_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end
endmodule

// File: rtl/cpf_peak_sel.sv
`timescale 1ns/1ps
module cpf_peak_sel
    import cpf_pkg::*;
#(
    parameter int unsigned SUM_W = DEF_SUM_W,
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             accept,
    input  logic [SUM_W-1:0] new_sum,
    input  logic             new_full,
    output logic             is_peak,
    output logic [SUM_W-1:0] peak_sum,
    output logic [CNT_W-1:0] peak_bx
);
    typedef struct packed {
        logic [SUM_W-1:0] cur_sum;
        logic             cur_ok;
        logic [SUM_W-1:0] prv_sum;
        logic [CNT_W-1:0] cur_bx;
        logic [CNT_W-1:0] bx_cnt;
    } peak_state_t;

    peak_state_t ps_d, ps_q;
    logic rises, holds;

    always_comb begin
        rises    = ps_q.cur_sum > ps_q.prv_sum;
        holds    = ps_q.cur_sum >= new_sum;
        is_peak  = accept && ps_q.cur_ok && rises && holds;
        peak_sum = ps_q.cur_sum;
        peak_bx  = ps_q.cur_bx;

        ps_d = ps_q;
        if (accept) begin
            ps_d.prv_sum = ps_q.cur_ok ? ps_q.cur_sum : '0;
            ps_d.cur_sum = new_sum;
            ps_d.cur_ok  = new_full;
            ps_d.cur_bx  = ps_q.bx_cnt;
            ps_d.bx_cnt  = ps_q.bx_cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ps_q <= '0;
        else     ps_q <= ps_d;
    end
endmodule

// File: rtl/cpf_range_comp.sv
`timescale 1ns/1ps
module cpf_range_comp
    import cpf_pkg::*;
#(
    parameter int unsigned SUM_W   = DEF_SUM_W,
    parameter int unsigned CODE_W  = DEF_CODE_W,
    parameter int unsigned LO_END  = DEF_LO_END,
    parameter int unsigned MID_END = DEF_MID_END,
    parameter int unsigned MID_SH  = DEF_MID_SH,
    parameter int unsigned HI_SH   = DEF_HI_SH
) (
    input  logic [SUM_W-1:0]  sum,
    output logic [CODE_W-1:0] code
);
    localparam int unsigned RW      = SUM_W + 1;
    localparam int unsigned HI_BASE = LO_END + ((MID_END - LO_END) >> MID_SH);
    localparam logic [RW-1:0] LO_V   = RW'(LO_END);
    localparam logic [RW-1:0] MID_V  = RW'(MID_END);
    localparam logic [RW-1:0] HIB_V  = RW'(HI_BASE);
    localparam logic [RW-1:0] CMAX_V = RW'((64'd1 << CODE_W) - 64'd1);

    logic [RW-1:0] ext, raw;
    seg_e          seg;

    always_comb begin
        ext = {1'b0, sum};
        if (ext < LO_V)       seg = SEG_FINE;
        else if (ext < MID_V) seg = SEG_MEDIUM;
        else                  seg = SEG_COARSE;

        case (seg)
            SEG_FINE:   raw = ext;
            SEG_MEDIUM: raw = LO_V + ((ext - LO_V) >> MID_SH);
            default:    raw = HIB_V + ((ext - MID_V) >> HI_SH);
        endcase
    end

    generate
        if (CODE_W >= RW) begin : g_wide
            assign code = CODE_W'(raw);
        end else begin : g_clamp
            assign code = (raw > CMAX_V) ? {CODE_W{1'b1}} : raw[CODE_W-1:0];
        end
    endgenerate
endmodule

// File: rtl/calo_peak_finder.sv
`timescale 1ns/1ps
module calo_peak_finder
    import cpf_pkg::*;
#(
    parameter int unsigned SAMPLE_W = DEF_SAMPLE_W,
    parameter int unsigned WIN      = DEF_WIN,
    parameter int unsigned SUM_W    = DEF_SUM_W,
    parameter int unsigned CODE_W   = DEF_CODE_W,
    parameter int unsigned CNT_W    = DEF_CNT_W,
    parameter int unsigned LO_END   = DEF_LO_END,
    parameter int unsigned MID_END  = DEF_MID_END,
    parameter int unsigned MID_SH   = DEF_MID_SH,
    parameter int unsigned HI_SH    = DEF_HI_SH
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_data,
    input  logic [SUM_W-1:0]    thresh,
    output logic                out_valid,
    output logic [CODE_W-1:0]   out_energy,
    output logic [CNT_W-1:0]    out_bx,
    output logic                out_over_thr
);
    typedef struct packed {
        logic              valid;
        logic [CODE_W-1:0] energy;
        logic [CNT_W-1:0]  bx;
        logic              over;
    } out_word_t;

    logic [SUM_W-1:0]  win_sum;
    logic              win_full;
    logic              is_peak;
    logic [SUM_W-1:0]  peak_sum;
    logic [CNT_W-1:0]  peak_bx;
    logic [CODE_W-1:0] peak_code;
    out_word_t         ow_d, ow_q;

    cpf_window_sum #(
        .SAMPLE_W (SAMPLE_W),
        .WIN      (WIN),
        .SUM_W    (SUM_W)
    ) u_win (
        .clk      (clk),
        .rst      (rst),
        .accept   (smp_valid),
        .sample   (smp_data),
        .win_sum  (win_sum),
        .win_full (win_full)
    );

    cpf_peak_sel #(
        .SUM_W    (SUM_W),
        .CNT_W    (CNT_W)
    ) u_peak (
        .clk      (clk),
        .rst      (rst),
        .accept   (smp_valid),
        .new_sum  (win_sum),
        .new_full (win_full),
        .is_peak  (is_peak),
        .peak_sum (peak_sum),
        .peak_bx  (peak_bx)
    );

    cpf_range_comp #(
        .SUM_W    (SUM_W),
        .CODE_W   (CODE_W),
        .LO_END   (LO_END),
        .MID_END  (MID_END),
        .MID_SH   (MID_SH),
        .HI_SH    (HI_SH)
    ) u_comp (
        .sum      (peak_sum),
        .code     (peak_code)
    );

    always_comb begin
        ow_d = '0;
        if (is_peak) begin
            ow_d.valid  = 1'b1;
            ow_d.energy = peak_code;
            ow_d.bx     = peak_bx;
            ow_d.over   = (peak_sum >= thresh);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) ow_q <= '0;
        else     ow_q <= ow_d;
    end

    assign out_valid    = ow_q.valid;
    assign out_energy   = ow_q.energy;
    assign out_bx       = ow_q.bx;
    assign out_over_thr = ow_q.over;
endmodule

// File: rtl/calo_peak_finder_chk.sv
`timescale 1ns/1ps
module calo_peak_finder_chk (
    input logic clk,
    input logic rst,
    input logic smp_valid,
    input logic out_valid,
    input logic out_over_thr
);
    logic [2:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst)                              seen_q <= '0;
        else if (smp_valid && seen_q != 3'd7) seen_q <= seen_q + 3'd1;
    end

    // R1: the cycle after reset has nothing on the output
    a_r1_reset_clear: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && !out_over_thr));

    // R3: a word needs seven accepted samples since reset
    a_r3_window_filled: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q == 3'd7));

    // R4 / R5: two neighbouring crossings cannot both be peaks
    a_r5_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        out_valid |=> !out_valid);

    // R9: an idle cycle never yields a word
    a_r9_idle_no_emit: assert property (@(posedge clk) disable iff (rst)
        !smp_valid |=> !out_valid);

    // R7: the threshold flag only accompanies a word
    a_r7_flag_gated: assert property (@(posedge clk) disable iff (rst)
        out_over_thr |-> out_valid);
endmodule

bind calo_peak_finder calo_peak_finder_chk u_chk (
    .clk          (clk),
    .rst          (rst),
    .smp_valid    (smp_valid),
    .out_valid    (out_valid),
    .out_over_thr (out_over_thr)
);

// File: tb/calo_peak_finder_tb.sv
`timescale 1ns/1ps
module calo_peak_finder_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        smp_valid = 1'b0;
    logic [9:0]  smp_data = '0;
    logic [12:0] thresh = '0;
    logic        out_valid;
    logic [7:0]  out_energy;
    logic [11:0] out_bx;
    logic        out_over_thr;

    int checks = 0;
    int failures = 0;
    int n = 0;
    int hist [0:7];
    int thr_now = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    calo_peak_finder u_dut (
        .clk          (clk),
        .rst          (rst),
        .smp_valid    (smp_valid),
        .smp_data     (smp_data),
        .thresh       (thresh),
        .out_valid    (out_valid),
        .out_energy   (out_energy),
        .out_bx       (out_bx),
        .out_over_thr (out_over_thr)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int wsum(input int k);
        int s = 0;
        for (int j = 0; j < 6; j++) s += hist[(k - j) & 7];
        return (s > 8191) ? 8191 : s;
    endfunction

    function automatic int comp(input int s);
        int c;
        if (s < 64)       c = s;
        else if (s < 320) c = 64 + ((s - 64) >> 2);
        else              c = 128 + ((s - 320) >> 4);
        return (c > 255) ? 255 : c;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        smp_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R1 valid", int'(out_valid), 0);
        chk(out_energy == 8'd0, "R1 energy", int'(out_energy), 0);
        chk(out_bx == 12'd0, "R1 bx", int'(out_bx), 0);
        chk(out_over_thr == 1'b0, "R1 over", int'(out_over_thr), 0);
        @(negedge clk);
        rst = 1'b0;
        n = 0;
        for (int i = 0; i < 8; i++) hist[i] = 0;
    endtask

    task automatic send(input int x, input int t);
        bit pk;
        int sk, sp;
        @(negedge clk);
        smp_valid = 1'b1;
        smp_data  = 10'(x);
        thresh    = 13'(t);
        thr_now   = t;
        hist[n & 7] = x;
        @(posedge clk);
        #1;
        pk = 1'b0;
        sk = 0;
        if (n >= 6) begin
            sk = wsum(n - 1);
            sp = (n >= 7) ? wsum(n - 2) : 0;
            pk = (sk > sp) && (sk >= wsum(n));
        end
        if (n < 6)
            chk(out_valid == 1'b0, "R3 early valid", int'(out_valid), 0);
        else
            chk(out_valid == pk, "R4 R5 valid", int'(out_valid), int'(pk));
        if (pk && out_valid) begin
            chk(int'(out_energy) == comp(sk), "R2 R6 energy", int'(out_energy), comp(sk));
            chk(int'(out_bx) == ((n - 1) % 4096), "R8 bx", int'(out_bx), (n - 1) % 4096);
            chk(out_over_thr == (sk >= thr_now), "R7 over", int'(out_over_thr), int'(sk >= thr_now));
        end
        if (!out_valid)
            chk(out_over_thr == 1'b0, "R7 gated", int'(out_over_thr), 0);
        n++;
    endtask

    task automatic idle();
        @(negedge clk);
        smp_valid = 1'b0;
        @(posedge clk);
        #1;
        chk(out_valid == 1'b0, "R9 idle", int'(out_valid), 0);
    endtask

    initial begin
        for (int i = 0; i < 8; i++) hist[i] = 0;
        do_reset();

        // all-zero stream: nothing emitted (R5)
        for (int i = 0; i < 10; i++) send(0, 0);

        // single spike, plateau of six equal sums, one word (R4)
        send(500, 400);
        for (int i = 0; i < 8; i++) send(0, 400);

        // first full window is the peak, clamp and threshold equality (R3 R6 R7)
        do_reset();
        for (int i = 0; i < 6; i++) send(1000, 6000);
        for (int i = 0; i < 8; i++) send(0, 6000);

        // full-scale plateau
        for (int i = 0; i < 10; i++) send(1023, 8000);
        for (int i = 0; i < 7; i++) send(0, 8000);

        // amplitude sweep over all segments, idle gaps, counter wrap (R6 R8 R9)
        for (int v = 1; v < 1024; v++) begin
            send(v, ((v & 1) != 0) ? v : v + 1);
            if ((v % 3) == 0) idle();
            for (int i = 0; i < 6; i++) send(0, ((v & 1) != 0) ? v : v + 1);
        end

        // irregular stream with ties and gaps
        do_reset();
        for (int i = 0; i < 3000; i++) begin
            int r;
            r = int'($urandom_range(0, 3));
            if (r == 0) send(0, int'($urandom_range(0, 6500)));
            else        send(int'($urandom_range(0, 1023)), int'($urandom_range(0, 6500)));
            if ($urandom_range(0, 7) == 0) idle();
            if ($urandom_range(0, 15) == 0) send(int'(smp_data), thr_now);
        end

        // reset in mid-stream restarts the window fill (R1 R3)
        for (int i = 0; i < 4; i++) send(900, 100);
        do_reset();
        for (int i = 0; i < 5; i++) send(800, 100);
        for (int i = 0; i < 8; i++) send(0, 100);

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule